// File: doc/BRIEF.md
# Multi-Buffer Single-Channel DMA Sequencer

This block drives one DMA channel that copies a chain of equal-sized buffers from a source area to a destination area, one word at a time. Software sets the start addresses, the buffer length in words and a few mode bits, then writes the enable pulse. The channel reads each word from the source pointer and writes it to the destination pointer over a simple request/ready memory port. Both pointers then step by one word.

When a buffer ends, the channel sets a buffer-done flag and picks one of three paths. If auto mode is off, that buffer is the last one and the channel goes idle by itself. If auto mode is on and the done interrupt is unmasked, the channel halts in a stalled state until software writes the keep-on pulse. If auto mode is on and the interrupt is masked, the next buffer starts at once. The source and destination reload bits decide, each on its own, whether a pointer returns to its start value at each new buffer or carries on from where it stopped.

Software learns that the whole transfer has ended by polling the active status until it reads 0. Auto mode is sampled only at the moment a buffer completes, so clearing it during the final buffer ends the chain cleanly.

Top module: `dma_mbuf_chan`

## Requirements
- R1: After reset, `chan_active`, `chan_stalled`, `buf_done`, `irq` and `mem_req` are all 0.
- R2: An `start_wr` pulse while idle with a nonzero `buf_len` sets `chan_active` on the next clock edge and loads both pointers from their start values. An `start_wr` pulse while active, or with `buf_len` equal to 0, has no effect.
- R3: Each word is one read (`mem_we`=0) at the source pointer followed by one write (`mem_we`=1) at the destination pointer, carrying the data of that read. A request holds its address and direction until `mem_ready` is 1, and the access completes only on a clock edge where both `mem_req` and `mem_ready` are 1.
- R4: A buffer completes after `buf_len` writes. At that edge `buf_done` is set, and `irq` equals `buf_done` AND `irq_unmask`.
- R5: At each new buffer, a pointer whose reload bit (`reload_src` or `reload_dst`) is 1 returns to its start address. A pointer whose reload bit is 0 keeps counting up by one per word across buffer boundaries.
- R6: With `auto_mode`=1 and `irq_unmask`=1, a completed buffer puts the channel into the stalled state (`chan_stalled`=1), and it makes no memory requests there. A `keepon_wr` pulse clears `chan_stalled` on the next edge and starts the next buffer.
- R7: With `auto_mode`=1 and `irq_unmask`=0, the next buffer starts right after the last write of the previous one, with no stall.
- R8: `auto_mode` is sampled only on the edge where a buffer completes. If it is 0 there, that buffer was the last one, and `chan_active` clears on the same edge. The total word count is `buf_len` times the number of buffers run.
- R9: An `ack_wr` pulse clears `buf_done`, and with it `irq`. A `keepon_wr` pulse while the channel is not stalled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Enable write pulse |
| keepon_wr | input | 1 | Keep-on write pulse, resumes a stalled channel |
| ack_wr | input | 1 | Write-1-to-clear pulse for the buffer-done flag |
| auto_mode | input | 1 | 1 = chain another buffer after the current one |
| reload_src | input | 1 | 1 = source pointer returns to its start at each buffer |
| reload_dst | input | 1 | 1 = destination pointer returns to its start at each buffer |
| irq_unmask | input | 1 | 1 = buffer-done interrupt enabled, stall at boundaries |
| src_start | input | AW | Source start word address |
| dst_start | input | AW | Destination start word address |
| buf_len | input | LW | Buffer length in words |
| chan_active | output | 1 | Channel enable status |
| chan_stalled | output | 1 | Stalled status |
| buf_done | output | 1 | Buffer-done flag |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid when a read completes |
| mem_ready | input | 1 | Memory accepts the current access |

## Verification
The bench builds the block with an 8-bit word address, a 4-bit length field and 32-bit data, so the source and destination windows fit in a small address space. Each word's data is an arithmetic function of its address, which lets every read address, write address and data word be checked as it happens. The bench sweeps buffer lengths 1 to 6 over all four reload combinations and both mask settings, with chains of one to three buffers. It alternates between an always-ready memory and a memory that stalls every third cycle. The short lengths put single-word buffers, stall-and-resume at each boundary, and auto mode being cleared during the final buffer within a few hundred cycles per case.

// File: rtl/dma_mbuf_pkg.sv
package dma_mbuf_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_READ  = 2'd1,
        CH_WRITE = 2'd2,
        CH_HOLD  = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        BD_CONTINUE = 2'd0,
        BD_STALL    = 2'd1,
        BD_FINISH   = 2'd2
    } bnd_act_e;

    localparam int NUM_PTR = 2;
    localparam int PTR_SRC = 0;
    localparam int PTR_DST = 1;

    // Decision taken on the edge where the last word of a buffer is written
    function automatic bnd_act_e boundary_action(input logic auto_on, input logic unmask);
        if (!auto_on)
            return BD_FINISH;
        else if (unmask)
            return BD_STALL;
        else
            return BD_CONTINUE;
    endfunction

    function automatic logic is_busy(input ch_state_e s);
        return (s == CH_READ) || (s == CH_WRITE);
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_mbuf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_first,
    input  logic          load_next,
    input  logic          step,
    input  logic          reload_src,
    input  logic          reload_dst,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr
);

    logic [NUM_PTR-1:0][AW-1:0] start_v;
    logic [NUM_PTR-1:0]         reload_v;
    logic [NUM_PTR-1:0][AW-1:0] ptr_v;

    assign start_v[PTR_SRC]  = src_start;
    assign start_v[PTR_DST]  = dst_start;
    assign reload_v[PTR_SRC] = reload_src;
    assign reload_v[PTR_DST] = reload_dst;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic [AW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (load_first)
                q <= start_v[g];
            else if (load_next && reload_v[g])
                q <= start_v[g];
            else if (step)
                q <= q + 1'b1;
        end
        assign ptr_v[g] = q;
    end

    assign src_addr = ptr_v[PTR_SRC];
    assign dst_addr = ptr_v[PTR_DST];

endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec,
    input  logic [LW-1:0] buf_len,
    output logic          len_nonzero,
    output logic          last_word,
    output logic [LW-1:0] remain
);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= buf_len;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign len_nonzero = |buf_len;
    assign last_word   = (cnt_q == {{(LW-1){1'b0}}, 1'b1});
    assign remain      = cnt_q;

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_mbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_wr,
    input  logic      keepon_wr,
    input  logic      ack_wr,
    input  logic      auto_mode,
    input  logic      irq_unmask,
    input  logic      len_nonzero,
    input  logic      last_word,
    input  logic      mem_ready,
    output ch_state_e state,
    output logic      load_first,
    output logic      load_next,
    output logic      rd_hs,
    output logic      wr_hs,
    output logic      flag
);

    ch_state_e state_q, state_d;
    logic      flag_q;
    logic      boundary;
    logic      resume;
    bnd_act_e  act;

    always_comb begin
        rd_hs      = (state_q == CH_READ)  && mem_ready;
        wr_hs      = (state_q == CH_WRITE) && mem_ready;
        boundary   = wr_hs && last_word;
        act        = boundary_action(auto_mode, irq_unmask);
        load_first = (state_q == CH_IDLE) && start_wr && len_nonzero;
        resume     = (state_q == CH_HOLD) && keepon_wr;
        load_next  = (boundary && act == BD_CONTINUE) || resume;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            CH_IDLE:  if (load_first) state_d = CH_READ;
            CH_READ:  if (rd_hs) state_d = CH_WRITE;
            CH_WRITE: begin
                if (wr_hs) begin
                    if (!last_word)
                        state_d = CH_READ;
                    else begin
                        case (act)
                            BD_CONTINUE: state_d = CH_READ;
                            BD_STALL:    state_d = CH_HOLD;
                            default:     state_d = CH_IDLE;
                        endcase
                    end
                end
            end
            CH_HOLD:  if (resume) state_d = CH_READ;
            default:  state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (boundary)
                flag_q <= 1'b1;
            else if (ack_wr)
                flag_q <= 1'b0;
        end
    end

    assign state = state_q;
    assign flag  = flag_q;

    // R6: a stalled channel stays stalled until keep-on arrives
    a_r6_hold_until_keepon: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_HOLD && !keepon_wr) |=> (state_q == CH_HOLD));

    // R4: a completed buffer always leaves the done flag set
    a_r4_flag_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && last_word) |=> flag_q);

    // R8: with auto off at completion the channel is idle next cycle
    a_r8_finish_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && last_word && !auto_mode) |=> (state_q == CH_IDLE));

endmodule

// File: rtl/dma_mbuf_chan.sv
module dma_mbuf_chan
    import dma_mbuf_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_wr,
    input  logic          keepon_wr,
    input  logic          ack_wr,
    input  logic          auto_mode,
    input  logic          reload_src,
    input  logic          reload_dst,
    input  logic          irq_unmask,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic [LW-1:0] buf_len,
    output logic          chan_active,
    output logic          chan_stalled,
    output logic          buf_done,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    ch_state_e     st;
    logic          load_first, load_next, rd_hs, wr_hs, flag;
    logic          len_nonzero, last_word;
    logic [LW-1:0] remain;
    logic [AW-1:0] src_addr, dst_addr;
    logic [DW-1:0] data_q;

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_wr   (start_wr),
        .keepon_wr  (keepon_wr),
        .ack_wr     (ack_wr),
        .auto_mode  (auto_mode),
        .irq_unmask (irq_unmask),
        .len_nonzero(len_nonzero),
        .last_word  (last_word),
        .mem_ready  (mem_ready),
        .state      (st),
        .load_first (load_first),
        .load_next  (load_next),
        .rd_hs      (rd_hs),
        .wr_hs      (wr_hs),
        .flag       (flag)
    );

    dma_len_ctr #(.LW(LW)) u_len (
        .clk        (clk),
        .rst        (rst),
        .load       (load_first || load_next),
        .dec        (wr_hs),
        .buf_len    (buf_len),
        .len_nonzero(len_nonzero),
        .last_word  (last_word),
        .remain     (remain)
    );

    dma_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load_first(load_first),
        .load_next (load_next),
        .step      (wr_hs),
        .reload_src(reload_src),
        .reload_dst(reload_dst),
        .src_start (src_start),
        .dst_start (dst_start),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (rd_hs)
            data_q <= mem_rdata;
    end

    assign mem_req      = is_busy(st);
    assign mem_we       = (st == CH_WRITE);
    assign mem_addr     = (st == CH_WRITE) ? dst_addr : src_addr;
    assign mem_wdata    = data_q;
    assign chan_active  = (st != CH_IDLE);
    assign chan_stalled = (st == CH_HOLD);
    assign buf_done     = flag;
    assign irq          = flag && irq_unmask;

    // R3: an access waiting for ready keeps its address and direction
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: no memory traffic while stalled
    a_r6_quiet_stall: assert property (@(posedge clk) disable iff (rst)
        chan_stalled |-> !mem_req);

    // R8: an inactive channel issues no requests
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !chan_active |-> !mem_req);

    // R9: keep-on releases a stall on the next edge
    a_r9_keepon_clears: assert property (@(posedge clk) disable iff (rst)
        (chan_stalled && keepon_wr) |=> !chan_stalled);

    // R4: word counter never sits at zero during a transfer
    a_r4_count_live: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (remain != '0));

    // R2: an enable write while active does not reload the counter
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (chan_active && start_wr && !wr_hs && !load_next) |=> $stable(remain));

endmodule

// File: tb/tb_dma_mbuf_chan.sv
`timescale 1ns/1ps
module tb_dma_mbuf_chan;

    localparam int AW = 8;
    localparam int LW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_wr, keepon_wr, ack_wr;
    logic          auto_cfg, reload_src, reload_dst, irq_unmask;
    logic [AW-1:0] src_start, dst_start;
    logic [LW-1:0] buf_len;
    logic          chan_active, chan_stalled, buf_done, irq;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          auto_mode;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int rd_idx = 0;
    int wr_idx = 0;
    int stop_at = 0;
    int rdy_mode = 0;
    int cur_len = 1;
    logic cur_rs = 1'b0;
    logic cur_rd = 1'b0;
    logic run_clr = 1'b0;

    always #4 clk = ~clk;

    dma_mbuf_chan #(.AW(AW), .LW(LW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start_wr(start_wr), .keepon_wr(keepon_wr), .ack_wr(ack_wr),
        .auto_mode(auto_mode), .reload_src(reload_src), .reload_dst(reload_dst),
        .irq_unmask(irq_unmask), .src_start(src_start), .dst_start(dst_start),
        .buf_len(buf_len), .chan_active(chan_active), .chan_stalled(chan_stalled),
        .buf_done(buf_done), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [DW-1:0] fval(input logic [AW-1:0] a);
        return {a, 8'hA5, ~a, a ^ 8'h3C};
    endfunction

    function automatic logic [AW-1:0] exp_src(input int i);
        return AW'(int'(src_start) + (cur_rs ? i % cur_len : i));
    endfunction

    function automatic logic [AW-1:0] exp_dst(input int i);
        return AW'(int'(dst_start) + (cur_rd ? i % cur_len : i));
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    assign mem_rdata = fval(mem_addr);
    // auto mode drops once the first word of the final buffer is recorded
    assign auto_mode = auto_cfg && !(stop_at != 0 && wr_idx >= stop_at);

    // memory model: ready chosen at the falling edge, handshake at the next rising edge
    always @(negedge clk) begin
        cyc++;
        mem_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        if (run_clr) begin
            rd_idx = 0;
            wr_idx = 0;
        end else if (mem_req && mem_ready) begin
            if (!mem_we) begin
                chk("R3 read address", mem_addr, exp_src(rd_idx));
                rd_idx++;
            end else begin
                chk("R5 write address", mem_addr, exp_dst(wr_idx));
                chk("R3 write data", mem_wdata, fval(exp_src(wr_idx)));
                wr_idx++;
            end
        end
    end

    task automatic run_case(input int len, input logic rs, input logic rd,
                            input int nbuf, input logic unm, input logic restart);
        int stalls;
        int guard;
        int w;
        @(negedge clk);
        buf_len    = LW'(len);
        reload_src = rs;
        reload_dst = rd;
        irq_unmask = unm;
        auto_cfg   = (nbuf > 1);
        stop_at    = (nbuf > 1) ? (nbuf - 1) * len + 1 : 0;
        cur_len    = len;
        cur_rs     = rs;
        cur_rd     = rd;
        rdy_mode   = len % 2;
        ack_wr     = 1'b1;
        @(posedge clk); run_clr = 1'b1;
        @(posedge clk); run_clr = 1'b0;
        @(negedge clk);
        ack_wr = 1'b0;
        chk("R9 ack clears done flag", buf_done, 0);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        chk("R2 enable sets active", chan_active, 1);
        if (restart) begin
            repeat (3) @(negedge clk);
            start_wr = 1'b1;
            @(negedge clk);
            start_wr = 1'b0;
        end
        stalls = 0;
        guard  = 0;
        while (chan_active && guard < 3000) begin
            if (chan_stalled) begin
                stalls++;
                chk("R6 stall at buffer boundary", wr_idx % len, 0);
                chk("R4 irq while stalled and unmasked", irq, 1);
                w = wr_idx;
                repeat (4) begin
                    @(negedge clk);
                    chk("R6 no request while stalled", mem_req, 0);
                end
                chk("R6 no words while stalled", wr_idx, w);
                ack_wr = 1'b1;
                @(negedge clk);
                ack_wr = 1'b0;
                chk("R9 ack clears flag", buf_done, 0);
                chk("R9 ack clears irq", irq, 0);
                chk("R6 still stalled after ack", chan_stalled, 1);
                keepon_wr = 1'b1;
                @(negedge clk);
                keepon_wr = 1'b0;
                chk("R6 keep-on releases stall", chan_stalled, 0);
            end
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) chk("R8 transfer ends (timeout)", 0, 1);
        chk("R8 total writes", wr_idx, len * nbuf);
        chk("R3 total reads", rd_idx, len * nbuf);
        chk("R7 stall count", stalls, unm ? nbuf - 1 : 0);
        chk("R4 done flag after last buffer", buf_done, 1);
        chk("R4 irq follows mask", irq, unm);
        chk("R8 active clears by itself", chan_active, 0);
    endtask

    initial begin
        #(8 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start_wr = 1'b0; keepon_wr = 1'b0; ack_wr = 1'b0;
        auto_cfg = 1'b0; reload_src = 1'b0; reload_dst = 1'b0; irq_unmask = 1'b0;
        src_start = 8'h10; dst_start = 8'h80; buf_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 active after reset", chan_active, 0);
        chk("R1 stalled after reset", chan_stalled, 0);
        chk("R1 done after reset", buf_done, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 request after reset", mem_req, 0);

        keepon_wr = 1'b1;
        @(negedge clk);
        keepon_wr = 1'b0;
        chk("R9 keep-on in idle ignored", chan_stalled, 0);
        chk("R9 keep-on in idle no request", mem_req, 0);

        buf_len  = '0;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        chk("R2 zero length enable ignored", chan_active, 0);
        @(negedge clk);
        chk("R2 zero length no request", mem_req, 0);

        for (int len = 1; len <= 6; len++) begin
            for (int rl = 0; rl < 4; rl++) begin
                for (int um = 0; um < 2; um++) begin
                    run_case(len, rl[0], rl[1], 1 + (len + rl) % 3, um[0], 1'b0);
                end
            end
        end

        // R2: enable writes during a run change nothing
        run_case(4, 1'b1, 1'b1, 2, 1'b0, 1'b1);
        run_case(3, 1'b0, 1'b0, 1, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule